// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Detection

This block manages 32 general-purpose lines behind a small 32-bit register bus. Each line can be an input or an output. Output lines drive the value held in a data register. Input lines pass through a two-flop synchronizer and are then captured into a pad-status register. A read of the data register returns a mix: the driven value for output lines and the captured pad value for input lines.

Every line has its own interrupt detector. A two-bit trigger field selects one of four triggers: level low, level high, rising edge or falling edge. A separate per-line override makes the line fire on any change of level. A mask gates detection. Detected events collect in a sticky status register, and software clears a bit by writing 1 to it. A single interrupt output is high while any status bit is set.

A bus access is one request cycle. The block answers with an acknowledge pulse and the registered read data one cycle later. Software drops the request once it sees the acknowledge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: An access is taken on a clock edge where `bus_req` is high and `bus_ack` is low. `bus_ack` is high for exactly the next cycle, and `bus_rdata` carries the read result in that cycle (zero otherwise). Byte offsets are: 0x00 data, 0x04 direction, 0x08 pad status, 0x0C trigger fields for lines 0–15, 0x10 trigger fields for lines 16–31, 0x14 mask, 0x18 status, 0x1C any-edge override. Only accesses with `bus_be` = 4'hF at a word-aligned offset below 0x20 act. Any other access reads zero and writes nothing.
- R2: A direction bit of 1 makes the line an output. `pad_oe` equals the direction register and `pad_out` equals the data register.
- R3: A data-register read returns (data AND direction) OR (pad status AND NOT direction). Pad-status bits of output lines hold their value, and input changes on those lines raise no edge event.
- R4: A level on `pad_in` that is stable before clock edge k enters pad status at edge k+2. A read taken at edge k therefore still returns the old value.
- R5: Line n's trigger field is bits [2n+1:2n] of {trigger register for lines 16–31, trigger register for lines 0–15}. With the upper bit 0 the line is level-triggered: a low bit of 1 fires while pad status is 1, and a low bit of 0 fires while pad status is 0. The condition is evaluated every cycle, so a status bit cleared while its condition still holds is set again.
- R6: With the upper trigger bit 1 the line is edge-triggered. A low bit of 0 fires on a rising edge and 1 fires on a falling edge. An edge is the synchronized input differing from pad status on an input line. A steady level does not fire in edge mode.
- R7: When a line's override bit is 1, any edge on the line fires and its trigger field is ignored.
- R8: A status bit can become set only when its mask bit was 1 in the cycle before. A set bit stays set until software clears it.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it alone. A detection in the same cycle as the clear wins.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: A synchronous reset clears all registers, `bus_ack`, `bus_rdata` and `irq`.
- R12: With parameter `HAS_ANY_EDGE` = 0 the override register is absent, reads zero and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| pad_in | input | 32 | Asynchronous line inputs |
| pad_out | output | 32 | Driven line values |
| pad_oe | output | 32 | Per-line output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that the acknowledge is a single pulse following each accepted request. They also check that status bits never drop without a clear write, that no status bit rises on a line that was masked, and that output lines leave pad status untouched. The trigger types themselves can only be shown by the bench's scenarios: level firing and re-firing after a clear, rising versus falling selection, the override beating a live level condition, the two-edge synchronizer latency, the mixed data-register read, partial and unmapped accesses, and the variant without the override register. A cycle-level reference model in the bench also compares the pins and read data on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned GPIO_W = 32;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_PAD   = 3'd2,
        SEL_TRGLO = 3'd3,
        SEL_TRGHI = 3'd4,
        SEL_MASK  = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_ANY   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic edge_mode;  // 1 = edge, 0 = level
        logic pol;        // level: 1 high; edge: 1 falling
    } trig_cfg_t;

    typedef struct packed {
        logic     take;
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_op_t;

    function automatic logic trig_event(trig_cfg_t c, logic any_edge,
                                        logic held, logic fresh, logic moved);
        if (any_edge)
            return moved;
        else if (c.edge_mode)
            return moved & (fresh ^ c.pol);
        else
            return ~(held ^ c.pol);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] trig,
    input  logic [W-1:0]   mask,
    input  logic [W-1:0]   any_edge,
    input  logic [W-1:0]   dir,
    input  logic [W-1:0]   held,
    input  logic [W-1:0]   fresh,
    output logic [W-1:0]   hit
);
    for (genvar i = 0; i < W; i++) begin : g_line
        trig_cfg_t cfg;
        logic      moved;
        assign cfg    = trig_cfg_t'(trig[2*i +: 2]);
        assign moved  = ~dir[i] & (fresh[i] ^ held[i]);
        assign hit[i] = mask[i] & trig_event(cfg, any_edge[i], held[i], fresh[i], moved);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter bit          HAS_ANY_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe,
    output logic              irq
);
    localparam int unsigned W     = GPIO_W;
    localparam int unsigned WIN_B = 5;

    logic [W-1:0] data_q, dir_q, pad_q, trglo_q, trghi_q, mask_q, stat_q, any_q;
    logic [W-1:0] synced, hit, rd_val, clr;
    bus_op_t      op;

    gpio_sync #(.W(W), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .d (pad_in), .q (synced)
    );

    gpio_detect #(.W(W)) u_detect (
        .trig     ({trghi_q, trglo_q}),
        .mask     (mask_q),
        .any_edge (any_q),
        .dir      (dir_q),
        .held     (pad_q),
        .fresh    (synced),
        .hit      (hit)
    );

    always_comb begin
        logic ok;
        ok      = (bus_addr[ADDR_W-1:WIN_B] == '0) && (bus_addr[1:0] == 2'b00)
                  && (bus_be == 4'hF);
        op.take = bus_req & ~bus_ack;
        op.sel  = reg_sel_e'(bus_addr[4:2]);
        op.wr   = op.take & ok & bus_we;
        op.rd   = op.take & ok & ~bus_we;
    end

    always_comb begin
        unique case (op.sel)
            SEL_DATA:  rd_val = (data_q & dir_q) | (pad_q & ~dir_q);
            SEL_DIR:   rd_val = dir_q;
            SEL_PAD:   rd_val = pad_q;
            SEL_TRGLO: rd_val = trglo_q;
            SEL_TRGHI: rd_val = trghi_q;
            SEL_MASK:  rd_val = mask_q;
            SEL_STAT:  rd_val = stat_q;
            SEL_ANY:   rd_val = any_q;
            default:   rd_val = '0;
        endcase
    end

    assign clr = (op.wr && op.sel == SEL_STAT) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            dir_q     <= '0;
            pad_q     <= '0;
            trglo_q   <= '0;
            trghi_q   <= '0;
            mask_q    <= '0;
            stat_q    <= '0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= op.take;
            bus_rdata <= op.rd ? rd_val : '0;
            pad_q     <= (pad_q & dir_q) | (synced & ~dir_q);
            stat_q    <= (stat_q & ~clr) | hit;
            if (op.wr) begin
                unique case (op.sel)
                    SEL_DATA:  data_q  <= bus_wdata;
                    SEL_DIR:   dir_q   <= bus_wdata;
                    SEL_TRGLO: trglo_q <= bus_wdata;
                    SEL_TRGHI: trghi_q <= bus_wdata;
                    SEL_MASK:  mask_q  <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    if (HAS_ANY_EDGE) begin : g_any
        always_ff @(posedge clk) begin
            if (rst)
                any_q <= '0;
            else if (op.wr && op.sel == SEL_ANY)
                any_q <= bus_wdata;
        end
    end else begin : g_no_any
        assign any_q = '0;
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign irq     = |stat_q;

    // R1: acknowledge is a single pulse following an accepted request
    a_r1_ack_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> bus_ack);
    a_r1_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);
    // R8: status bits are sticky without a clear write
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R8: a newly set status bit had its mask set
    a_r8_masked_only: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));
    // R3: pad status of output lines holds
    a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pad_q ^ $past(pad_q)) & $past(dir_q)) == '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0, pad_in = '0;
    logic [31:0] bus_rdata, pad_out, pad_oe, rdata_b, pout_b, poe_b;
    logic        bus_ack, irq, ack_b, irq_b;

    int total = 0, bad = 0;
    logic [31:0] rd_a, rd_b;

    always #(PERIOD/2) clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

    gpio_irq_ctrl #(.HAS_ANY_EDGE(1'b0)) uut_b (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_ack(ack_b),
        .pad_in(pad_in), .pad_out(pout_b), .pad_oe(poe_b), .irq(irq_b));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model, stepped on every rising edge
    logic [31:0] m_s1, m_s2, m_pad, m_data, m_dir, m_lo, m_hi, m_mask, m_stat, m_any, m_rd;
    logic        m_ack;

    always @(posedge clk) begin
        if (rst) begin
            {m_s1, m_s2, m_pad, m_data, m_dir, m_lo, m_hi, m_mask, m_stat, m_any, m_rd} = '0;
            m_ack = 1'b0;
        end else begin
            logic [63:0] trg;
            logic [31:0] hits, nclr, val;
            bit take, good;
            trg = {m_hi, m_lo};
            hits = '0;
            for (int i = 0; i < 32; i++) begin
                bit moved, ev;
                moved = !m_dir[i] && (m_s2[i] != m_pad[i]);
                if (m_any[i])         ev = moved;
                else if (trg[2*i+1])  ev = moved && (m_s2[i] == !trg[2*i]);
                else                  ev = (m_pad[i] == trg[2*i]);
                hits[i] = m_mask[i] && ev;
            end
            take = bus_req && !m_ack;
            good = take && bus_be == 4'hF && bus_addr < 8'h20 && bus_addr[1:0] == 2'b00;
            case (bus_addr[4:2])
                0: val = (m_data & m_dir) | (m_pad & ~m_dir);
                1: val = m_dir;   2: val = m_pad;  3: val = m_lo;
                4: val = m_hi;    5: val = m_mask; 6: val = m_stat;
                default: val = m_any;
            endcase
            m_rd  = (good && !bus_we) ? val : '0;
            nclr  = (good && bus_we && bus_addr == 8'h18) ? bus_wdata : '0;
            m_stat = (m_stat & ~nclr) | hits;
            for (int i = 0; i < 32; i++) if (!m_dir[i]) m_pad[i] = m_s2[i];
            if (good && bus_we) begin
                case (bus_addr[4:2])
                    0: m_data = bus_wdata; 1: m_dir = bus_wdata; 3: m_lo = bus_wdata;
                    4: m_hi = bus_wdata;   5: m_mask = bus_wdata; 7: m_any = bus_wdata;
                    default: ;
                endcase
            end
            m_ack = take;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R10 irq vs model", {31'b0, irq}, {31'b0, |m_stat});
            check("R2 pad_out vs model", pad_out, m_data);
            check("R2 pad_oe vs model", pad_oe, m_dir);
            check("R1 ack vs model", {31'b0, bus_ack}, {31'b0, m_ack});
            check("R1 rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic access(bit we, logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        @(negedge clk);
        rd_a = bus_rdata; rd_b = rdata_b;
        bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        access(1'b1, a, d, 4'hF);
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
        access(1'b0, a, '0, 4'hF);
        check(tag, rd_a, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        for (int a = 0; a < 8; a++) rd("R11 register reset", 8'(a * 4), 32'h0);
        check("R11 irq reset", {31'b0, irq}, 32'h0);

        // R2 / R3 direction, outputs and mixed data read
        wr(8'h04, 32'h0000_00FF);
        wr(8'h00, 32'hA5A5_A5A5);
        check("R2 pad_out", pad_out, 32'hA5A5_A5A5);
        check("R2 pad_oe", pad_oe, 32'h0000_00FF);
        @(negedge clk) pad_in = 32'h1234_5678;
        idle(4);
        rd("R3 data mix", 8'h00, 32'h1234_56A5);
        rd("R3 pad status output lines held", 8'h08, 32'h1234_5600);

        // R1 unmapped and partial accesses
        rd("R1 unmapped read", 8'h20, 32'h0);
        access(1'b1, 8'h04, 32'h0, 4'h3);
        rd("R1 partial write ignored", 8'h04, 32'h0000_00FF);
        access(1'b0, 8'h04, 32'h0, 4'h1);
        check("R1 partial read zero", rd_a, 32'h0);

        // R5 level high on line 9, re-fires after clear; R9 detection wins
        wr(8'h0C, 32'h0004_0000);
        wr(8'h14, 32'h0000_0200);
        idle(2);
        rd("R5 level high fires", 8'h18, 32'h0000_0200);
        check("R10 irq high", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h0000_0200);
        rd("R9 detection beats clear", 8'h18, 32'h0000_0200);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd("R9 clear", 8'h18, 32'h0);
        check("R10 irq low", {31'b0, irq}, 32'h0);
        // R5 level low on line 8 (field 00)
        wr(8'h14, 32'h0000_0100);
        idle(2);
        rd("R5 level low fires", 8'h18, 32'h0000_0100);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        // R8 masked lines never set
        idle(3);
        rd("R8 masked stays clear", 8'h18, 32'h0);

        // R6 edges on line 16
        wr(8'h10, 32'h0000_0002);
        wr(8'h14, 32'h0001_0000);
        idle(3);
        rd("R6 no edge no event", 8'h18, 32'h0);
        @(negedge clk) pad_in = 32'h1235_5678;
        idle(5);
        rd("R6 rising fires", 8'h18, 32'h0001_0000);
        wr(8'h18, 32'h0001_0000);
        idle(2);
        rd("R6 steady high quiet", 8'h18, 32'h0);
        wr(8'h10, 32'h0000_0003);
        @(negedge clk) pad_in = 32'h1234_5678;
        idle(5);
        rd("R6 falling fires", 8'h18, 32'h0001_0000);
        wr(8'h18, 32'h0001_0000);
        @(negedge clk) pad_in = 32'h1235_5678;
        idle(5);
        rd("R6 rising ignored in falling mode", 8'h18, 32'h0);
        wr(8'h14, 32'h0);

        // R7 any-edge override on line 17 (field 00 would fire on low)
        wr(8'h1C, 32'h0002_0000);
        wr(8'h14, 32'h0002_0000);
        idle(3);
        rd("R7 override masks level", 8'h18, 32'h0);
        @(negedge clk) pad_in = 32'h1237_5678;
        idle(5);
        rd("R7 rise fires", 8'h18, 32'h0002_0000);
        wr(8'h18, 32'h0002_0000);
        @(negedge clk) pad_in = 32'h1235_5678;
        idle(5);
        rd("R7 fall fires", 8'h18, 32'h0002_0000);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);

        // R3 input change on output line 0 ignored
        wr(8'h1C, 32'h0000_0001);
        wr(8'h14, 32'h0000_0001);
        @(negedge clk) pad_in = 32'h1235_5679;
        idle(5);
        rd("R3 output line no event", 8'h18, 32'h0);
        rd("R3 output line pad held", 8'h08, 32'h1235_5600);
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'h0);

        // R4 synchronizer latency
        pad_in = 32'h1335_5679;
        rd("R4 not yet visible", 8'h08, 32'h1235_5600);
        idle(4);
        rd("R4 visible", 8'h08, 32'h1335_5600);

        // R12 variant without override register
        wr(8'h1C, 32'h0000_0005);
        access(1'b0, 8'h1C, '0, 4'hF);
        check("R12 override present reads back", rd_a, 32'h0000_0005);
        check("R12 override absent reads zero", rd_b, 32'h0);
        wr(8'h1C, 32'h0);

        idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule